// File: doc/BRIEF.md
# Tagged Return Target Stack

This block predicts where a translated return should branch when guest call/return pairs are emulated in dynamically translated code. On the call side, software pushes one entry. The entry holds a guest-side tag and the host address of the translated code that follows the call. The tag is made of three parts: the guest return address, a guest context value and the guest code-segment limit.

Before the matching return, software loads the real guest return address from the emulated guest stack. It writes that address into a dedicated guest-address register. A pop then compares the top entry's tag against that register and against the context and segment limit that apply at the time of the return. When all three parts match, the stored host target comes back as a trusted prediction. When any part differs, the block reports a miss so that software can fall back to a table lookup.

Every pop removes the top entry, whether it hits or misses, so the stack stays aligned with the call nesting. The storage is circular. Pushing past the depth silently replaces the oldest entry. A synchronous flush drops every entry, for example after a context switch or after the translation cache is invalidated.

Top module: `tagged_ret_stack`

## Requirements
- R1: After reset, `pop_valid_o`, `pop_hit_o`, `pop_target_o` and `gaddr_q_o` are all zero, and no entry is live, so a first pop misses.
- R2: A write on `gaddr_we_i` makes `gaddr_q_o` show `gaddr_wdata_i` from the next cycle onward. A pop uses the register value held in the cycle the pop is issued.
- R3: `pop_valid_o` is high for exactly one cycle, namely the cycle after a pop that was not flushed. It is low at every other time.
- R4: A pop hits when the top entry is live and its guest address, context and segment limit all equal the register value, `cur_ctx_i` and `cur_lim_i`. `pop_target_o` then carries that entry's host target.
- R5: If any one of the three tag parts differs, the pop reports a miss, and `pop_target_o` is zero.
- R6: Entries come back in last-in, first-out order across nested pushes.
- R7: A pop removes the top entry on a hit and on a miss alike, so the next pop examines the entry below it.
- R8: The stack holds 16 entries. After 17 pushes with no pops, 16 pops return the newest 16 entries and hit. The 17th pop misses, because the oldest entry was overwritten.
- R9: A pop issued while no entry is live reports a miss.
- R10: `flush_i` makes every entry not live from the next cycle. Any push or pop issued in the same cycle as a flush is discarded, and that pop produces no response.
- R11: When a push and a pop arrive in the same cycle, the pop is handled first and returns the old top. The pushed entry then takes its place, and the entries below stay untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Drop all entries; discards a push or pop in the same cycle |
| push_i | input | 1 | Call-side push request |
| push_gaddr_i | input | 32 | Guest return address for the new entry |
| push_ctx_i | input | 16 | Guest context value for the new entry |
| push_lim_i | input | 32 | Guest code-segment limit for the new entry |
| push_target_i | input | 32 | Translated host target for the new entry |
| gaddr_we_i | input | 1 | Write strobe for the guest-address register |
| gaddr_wdata_i | input | 32 | Guest return address loaded by software |
| gaddr_q_o | output | 32 | Current guest-address register value |
| pop_i | input | 1 | Return-side pop and tag check |
| cur_ctx_i | input | 16 | Context in effect at the return |
| cur_lim_i | input | 32 | Code-segment limit in effect at the return |
| pop_valid_o | output | 1 | Pop response strobe, one cycle after the pop |
| pop_hit_o | output | 1 | Tag matched; the target may be used |
| pop_target_o | output | 32 | Predicted host target on a hit, zero otherwise |

## Verification
The assertions assume that the control inputs are never unknown after reset. They also assume that software writes the guest-address register at least one cycle before the pop that should use it. The stimulus meets both conditions: it drives every control to a known level at reset and changes inputs only on the falling edge. Every pop sequence first writes the register, then issues the pop in the following cycle. The checker keeps its own saturating count of live entries. That count is valid only while pops and pushes follow this order, and the directed scenarios never go outside it.

// File: rtl/rts_pkg.sv
`timescale 1ns/1ps
// Package: shared operation encoding for the tagged return target stack.
// Assumes flush dominates every other request in a cycle.
package rts_pkg;

    // One stack operation per cycle after arbitration.
    typedef enum logic [1:0] {
        STK_HOLD = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2,
        STK_SWAP = 2'd3
    } stk_op_e;

    // Fold the request strobes into one operation; flush squashes both.
    function automatic stk_op_e decode_op(input logic push, input logic pop,
                                          input logic flush);
        stk_op_e op;
        if (flush)            op = STK_HOLD;
        else if (push && pop) op = STK_SWAP;
        else if (push)        op = STK_PUSH;
        else if (pop)         op = STK_POP;
        else                  op = STK_HOLD;
        return op;
    endfunction

endpackage

// File: rtl/rts_guest_reg.sv
`timescale 1ns/1ps
// Module: software-visible guest return address register.
// Holds the address that software loaded from the emulated guest stack.
// Assumes a write lands one cycle before the pop that should see it.
module rts_guest_reg #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] val_q;

    // Capture a software write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    val_q <= '0;
        else if (we_i) val_q <= wdata_i;
    end

    assign q_o = val_q;

endmodule

// File: rtl/rts_ptr_ctl.sv
`timescale 1ns/1ps
// Module: circular top-of-stack pointer.
// The pointer names the next free slot; the top entry sits one below it.
// A pop always steps back, even on an empty stack, to keep nesting alignment.
// Assumes DEPTH >= 2.
module rts_ptr_ctl
    import rts_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  stk_op_e          op_i,
    output logic [PTR_W-1:0] top_idx_o,
    output logic [PTR_W-1:0] wr_idx_o
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_inc;
    logic [PTR_W-1:0] ptr_dec;

    // Wrapping neighbours of the pointer for any depth.
    always_comb begin
        ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        ptr_dec = (ptr_q == '0) ? LAST : ptr_q - 1'b1;
    end

    // Top entry index and the slot a push writes to (swap reuses the top).
    always_comb begin
        top_idx_o = ptr_dec;
        wr_idx_o  = (op_i == STK_SWAP) ? ptr_dec : ptr_q;
    end

    // Advance the pointer per operation; flush restarts at slot zero.
    always_ff @(posedge clk) begin
        if (!rst_n)       ptr_q <= '0;
        else if (flush_i) ptr_q <= '0;
        else begin
            case (op_i)
                STK_PUSH: ptr_q <= ptr_inc;
                STK_POP:  ptr_q <= ptr_dec;
                default:  ptr_q <= ptr_q;
            endcase
        end
    end

endmodule

// File: rtl/rts_entry_store.sv
`timescale 1ns/1ps
// Module: entry storage with one valid bit per slot.
// When a write and a clear hit the same slot in one cycle, the write wins,
// which gives pop-then-push ordering. Flush clears every valid bit.
module rts_entry_store #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned PTR_W = $clog2(DEPTH),
    parameter int unsigned ENT_W = 112
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             wr_en_i,
    input  logic [PTR_W-1:0] wr_idx_i,
    input  logic [ENT_W-1:0] wr_data_i,
    input  logic             clr_en_i,
    input  logic [PTR_W-1:0] clr_idx_i,
    input  logic [PTR_W-1:0] rd_idx_i,
    output logic             rd_valid_o,
    output logic [ENT_W-1:0] rd_data_o
);

    logic [DEPTH-1:0] vld_q;
    logic [ENT_W-1:0] data_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic hit_wr;
        logic hit_clr;
        assign hit_wr  = wr_en_i  && (wr_idx_i  == PTR_W'(i));
        assign hit_clr = clr_en_i && (clr_idx_i == PTR_W'(i));

        // Slot liveness: set by a write, dropped by a pop or a flush.
        always_ff @(posedge clk) begin
            if (!rst_n)       vld_q[i] <= 1'b0;
            else if (flush_i) vld_q[i] <= 1'b0;
            else if (hit_wr)  vld_q[i] <= 1'b1;
            else if (hit_clr) vld_q[i] <= 1'b0;
        end

        // Slot payload: loaded on a write to this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)      data_q[i] <= '0;
            else if (hit_wr) data_q[i] <= wr_data_i;
        end
    end

    // Top entry read port.
    always_comb begin
        rd_valid_o = vld_q[rd_idx_i];
        rd_data_o  = data_q[rd_idx_i];
    end

endmodule

// File: rtl/rts_tag_cmp.sv
`timescale 1ns/1ps
// Module: tag comparator.
// Reports a match only for a live entry whose guest address, context and
// segment limit all equal the probe values. Purely combinational.
module rts_tag_cmp #(
    parameter int unsigned GADDR_W = 32,
    parameter int unsigned CTX_W   = 16,
    parameter int unsigned LIM_W   = 32
) (
    input  logic               live_i,
    input  logic [GADDR_W-1:0] ent_gaddr_i,
    input  logic [CTX_W-1:0]   ent_ctx_i,
    input  logic [LIM_W-1:0]   ent_lim_i,
    input  logic [GADDR_W-1:0] probe_gaddr_i,
    input  logic [CTX_W-1:0]   probe_ctx_i,
    input  logic [LIM_W-1:0]   probe_lim_i,
    output logic               match_o
);

    logic eq_gaddr;
    logic eq_ctx;
    logic eq_lim;

    // Field-wise equality, then the combined verdict.
    always_comb begin
        eq_gaddr = (ent_gaddr_i == probe_gaddr_i);
        eq_ctx   = (ent_ctx_i   == probe_ctx_i);
        eq_lim   = (ent_lim_i   == probe_lim_i);
        match_o  = live_i && eq_gaddr && eq_ctx && eq_lim;
    end

endmodule

// File: rtl/tagged_ret_stack.sv
`timescale 1ns/1ps
// Module: tagged return target stack (top level).
// A push stores {guest addr, context, segment limit, host target}. A pop
// checks the top entry against the guest-address register and the live
// context and limit, then returns a registered hit/miss one cycle later.
// Assumes software writes the guest-address register before the pop.
module tagged_ret_stack
    import rts_pkg::*;
#(
    parameter int unsigned DEPTH   = 16,
    parameter int unsigned GADDR_W = 32,
    parameter int unsigned CTX_W   = 16,
    parameter int unsigned LIM_W   = 32,
    parameter int unsigned HOST_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush_i,
    input  logic               push_i,
    input  logic [GADDR_W-1:0] push_gaddr_i,
    input  logic [CTX_W-1:0]   push_ctx_i,
    input  logic [LIM_W-1:0]   push_lim_i,
    input  logic [HOST_W-1:0]  push_target_i,
    input  logic               gaddr_we_i,
    input  logic [GADDR_W-1:0] gaddr_wdata_i,
    output logic [GADDR_W-1:0] gaddr_q_o,
    input  logic               pop_i,
    input  logic [CTX_W-1:0]   cur_ctx_i,
    input  logic [LIM_W-1:0]   cur_lim_i,
    output logic               pop_valid_o,
    output logic               pop_hit_o,
    output logic [HOST_W-1:0]  pop_target_o
);

    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned ENT_W = GADDR_W + CTX_W + LIM_W + HOST_W;
    localparam int unsigned TGT_LO = 0;
    localparam int unsigned LIM_LO = TGT_LO + HOST_W;
    localparam int unsigned CTX_LO = LIM_LO + LIM_W;
    localparam int unsigned GA_LO  = CTX_LO + CTX_W;

    stk_op_e          op;
    logic             do_pop;
    logic             do_push;
    logic [PTR_W-1:0] top_idx;
    logic [PTR_W-1:0] wr_idx;
    logic [ENT_W-1:0] wr_ent;
    logic [ENT_W-1:0] top_ent;
    logic             top_live;
    logic             tag_match;
    logic [GADDR_W-1:0] greg;

    logic              rsp_vld_q;
    logic              rsp_hit_q;
    logic [HOST_W-1:0] rsp_tgt_q;

    // Arbitrate the request strobes into one operation.
    always_comb begin
        op      = decode_op(push_i, pop_i, flush_i);
        do_pop  = (op == STK_POP)  || (op == STK_SWAP);
        do_push = (op == STK_PUSH) || (op == STK_SWAP);
        wr_ent  = {push_gaddr_i, push_ctx_i, push_lim_i, push_target_i};
    end

    rts_guest_reg #(.W(GADDR_W)) u_greg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (gaddr_we_i),
        .wdata_i (gaddr_wdata_i),
        .q_o     (greg)
    );

    rts_ptr_ctl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (flush_i),
        .op_i      (op),
        .top_idx_o (top_idx),
        .wr_idx_o  (wr_idx)
    );

    rts_entry_store #(.DEPTH(DEPTH), .PTR_W(PTR_W), .ENT_W(ENT_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (flush_i),
        .wr_en_i    (do_push),
        .wr_idx_i   (wr_idx),
        .wr_data_i  (wr_ent),
        .clr_en_i   (do_pop),
        .clr_idx_i  (top_idx),
        .rd_idx_i   (top_idx),
        .rd_valid_o (top_live),
        .rd_data_o  (top_ent)
    );

    rts_tag_cmp #(.GADDR_W(GADDR_W), .CTX_W(CTX_W), .LIM_W(LIM_W)) u_cmp (
        .live_i        (top_live),
        .ent_gaddr_i   (top_ent[GA_LO +: GADDR_W]),
        .ent_ctx_i     (top_ent[CTX_LO +: CTX_W]),
        .ent_lim_i     (top_ent[LIM_LO +: LIM_W]),
        .probe_gaddr_i (greg),
        .probe_ctx_i   (cur_ctx_i),
        .probe_lim_i   (cur_lim_i),
        .match_o       (tag_match)
    );

    // Register the pop verdict; the target is zeroed unless trusted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld_q <= 1'b0;
            rsp_hit_q <= 1'b0;
            rsp_tgt_q <= '0;
        end else if (do_pop) begin
            rsp_vld_q <= 1'b1;
            rsp_hit_q <= tag_match;
            rsp_tgt_q <= tag_match ? top_ent[TGT_LO +: HOST_W] : '0;
        end else begin
            rsp_vld_q <= 1'b0;
            rsp_hit_q <= 1'b0;
            rsp_tgt_q <= '0;
        end
    end

    assign gaddr_q_o    = greg;
    assign pop_valid_o  = rsp_vld_q;
    assign pop_hit_o    = rsp_hit_q;
    assign pop_target_o = rsp_tgt_q;

endmodule

// File: rtl/rts_checker.sv
`timescale 1ns/1ps
// Module: property checker for tagged_ret_stack, attached by bind.
// Keeps its own saturating count of live entries to judge empty pops.
module rts_checker #(
    parameter int unsigned DEPTH   = 16,
    parameter int unsigned GADDR_W = 32,
    parameter int unsigned HOST_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush_i,
    input logic               push_i,
    input logic               pop_i,
    input logic               gaddr_we_i,
    input logic [GADDR_W-1:0] gaddr_wdata_i,
    input logic [GADDR_W-1:0] gaddr_q_o,
    input logic               pop_valid_o,
    input logic               pop_hit_o,
    input logic [HOST_W-1:0]  pop_target_o
);

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [CNT_W-1:0] live_q;

    // Independent occupancy model: pop first, then push, saturating at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) live_q <= '0;
        else if (push_i && pop_i) live_q <= (live_q == '0) ? CNT_W'(1) : live_q;
        else if (pop_i)  live_q <= (live_q == '0) ? '0 : live_q - 1'b1;
        else if (push_i) live_q <= (live_q == FULL) ? FULL : live_q + 1'b1;
    end

    AST_RESP_AFTER_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !flush_i) |=> pop_valid_o); // R3
    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop_i && !flush_i) |=> !pop_valid_o); // R3
    AST_HIT_NEEDS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        pop_hit_o |-> pop_valid_o); // R4
    AST_MISS_ZERO_TGT: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_hit_o |-> (pop_target_o == '0)); // R5
    AST_EMPTY_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !flush_i && live_q == '0) |=> !pop_hit_o); // R9
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_i ##1 (pop_i && !flush_i)) |=> !pop_hit_o); // R10
    AST_GREG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        gaddr_we_i |=> (gaddr_q_o == $past(gaddr_wdata_i))); // R2

endmodule

bind tagged_ret_stack rts_checker #(
    .DEPTH   (DEPTH),
    .GADDR_W (GADDR_W),
    .HOST_W  (HOST_W)
) u_rts_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush_i       (flush_i),
    .push_i        (push_i),
    .pop_i         (pop_i),
    .gaddr_we_i    (gaddr_we_i),
    .gaddr_wdata_i (gaddr_wdata_i),
    .gaddr_q_o     (gaddr_q_o),
    .pop_valid_o   (pop_valid_o),
    .pop_hit_o     (pop_hit_o),
    .pop_target_o  (pop_target_o)
);

// File: tb/tagged_ret_stack_tb_top.sv
`timescale 1ns/1ps
// Directed bench for tagged_ret_stack: one task per scenario.
module tagged_ret_stack_tb_top;

    localparam logic [15:0] CTX = 16'h0011;
    localparam logic [31:0] LIM = 32'h0000_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_i = 1'b0;
    logic        push_i = 1'b0;
    logic [31:0] push_gaddr_i = '0;
    logic [15:0] push_ctx_i = '0;
    logic [31:0] push_lim_i = '0;
    logic [31:0] push_target_i = '0;
    logic        gaddr_we_i = 1'b0;
    logic [31:0] gaddr_wdata_i = '0;
    logic [31:0] gaddr_q_o;
    logic        pop_i = 1'b0;
    logic [15:0] cur_ctx_i = '0;
    logic [31:0] cur_lim_i = '0;
    logic        pop_valid_o;
    logic        pop_hit_o;
    logic [31:0] pop_target_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    tagged_ret_stack dut_i (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
        .push_i(push_i), .push_gaddr_i(push_gaddr_i), .push_ctx_i(push_ctx_i),
        .push_lim_i(push_lim_i), .push_target_i(push_target_i),
        .gaddr_we_i(gaddr_we_i), .gaddr_wdata_i(gaddr_wdata_i), .gaddr_q_o(gaddr_q_o),
        .pop_i(pop_i), .cur_ctx_i(cur_ctx_i), .cur_lim_i(cur_lim_i),
        .pop_valid_o(pop_valid_o), .pop_hit_o(pop_hit_o), .pop_target_o(pop_target_o)
    );

    function automatic logic [31:0] ga(input int n);
        return 32'h0040_0000 + 32'(n) * 4;
    endfunction
    function automatic logic [31:0] tg(input int n);
        return 32'h8000_0000 + 32'(n) * 16;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] g, input logic [15:0] c,
                        input logic [31:0] l, input logic [31:0] t);
        @(negedge clk);
        push_i = 1'b1; push_gaddr_i = g; push_ctx_i = c; push_lim_i = l; push_target_i = t;
        @(negedge clk);
        push_i = 1'b0;
    endtask

    // Write the register, pop the next cycle, check the response after one edge.
    task automatic pop_chk(input logic [31:0] g, input logic [15:0] c,
                           input logic [31:0] l, input bit exp_hit,
                           input logic [31:0] exp_tgt, input string req);
        @(negedge clk);
        gaddr_we_i = 1'b1; gaddr_wdata_i = g;
        @(negedge clk);
        gaddr_we_i = 1'b0; pop_i = 1'b1; cur_ctx_i = c; cur_lim_i = l;
        @(negedge clk);
        pop_i = 1'b0;
        check(pop_valid_o == 1'b1, {req, " valid"}, 64'(pop_valid_o), 64'd1);
        check(pop_hit_o == exp_hit, {req, " hit"}, 64'(pop_hit_o), 64'(exp_hit));
        check(pop_target_o == exp_tgt, {req, " target"}, 64'(pop_target_o), 64'(exp_tgt));
    endtask

    task automatic t_reset;
        check(pop_valid_o == 1'b0, "R1 valid", 64'(pop_valid_o), 0);
        check(pop_hit_o == 1'b0, "R1 hit", 64'(pop_hit_o), 0);
        check(pop_target_o == '0, "R1 target", 64'(pop_target_o), 0);
        check(gaddr_q_o == '0, "R1 greg", 64'(gaddr_q_o), 0);
        pop_chk(32'h0, 16'h0, 32'h0, 1'b0, 32'h0, "R1 first pop");
    endtask

    task automatic t_greg;
        @(negedge clk);
        gaddr_we_i = 1'b1; gaddr_wdata_i = 32'hCAFE_0124;
        @(negedge clk);
        gaddr_we_i = 1'b0;
        check(gaddr_q_o == 32'hCAFE_0124, "R2 readback", 64'(gaddr_q_o), 64'hCAFE_0124);
    endtask

    task automatic t_basic_hit;
        push(ga(1), CTX, LIM, tg(1));
        pop_chk(ga(1), CTX, LIM, 1'b1, tg(1), "R4 hit");
        @(negedge clk);
        check(pop_valid_o == 1'b0, "R3 one-cycle strobe", 64'(pop_valid_o), 0);
    endtask

    task automatic t_field_miss;
        push(ga(2), CTX, LIM, tg(2));
        push(ga(3), CTX, LIM, tg(3));
        push(ga(4), CTX, LIM, tg(4));
        pop_chk(ga(9), CTX, LIM, 1'b0, 32'h0, "R5 gaddr differs");
        pop_chk(ga(3), CTX ^ 16'h1, LIM, 1'b0, 32'h0, "R5 ctx differs");
        pop_chk(ga(2), CTX, LIM + 1, 1'b0, 32'h0, "R5 lim differs");
        pop_chk(ga(2), CTX, LIM, 1'b0, 32'h0, "R9 empty pop");
        push(ga(5), CTX, LIM, tg(5));
        push(ga(6), CTX, LIM, tg(6));
        pop_chk(ga(7), CTX, LIM, 1'b0, 32'h0, "R7 miss removes");
        pop_chk(ga(5), CTX, LIM, 1'b1, tg(5), "R7 next below");
    endtask

    task automatic t_nesting;
        for (int n = 10; n < 15; n++) push(ga(n), CTX, LIM, tg(n));
        for (int n = 14; n >= 10; n--) pop_chk(ga(n), CTX, LIM, 1'b1, tg(n), "R6 lifo");
    endtask

    task automatic t_wrap;
        for (int n = 0; n < 17; n++) push(ga(20 + n), CTX, LIM, tg(20 + n));
        for (int n = 16; n >= 1; n--) pop_chk(ga(20 + n), CTX, LIM, 1'b1, tg(20 + n), "R8 newest");
        pop_chk(ga(20), CTX, LIM, 1'b0, 32'h0, "R8 oldest lost");
    endtask

    task automatic t_flush;
        push(ga(40), CTX, LIM, tg(40));
        push(ga(41), CTX, LIM, tg(41));
        @(negedge clk);
        flush_i = 1'b1;
        @(negedge clk);
        flush_i = 1'b0;
        pop_chk(ga(41), CTX, LIM, 1'b0, 32'h0, "R10 flushed top");
        pop_chk(ga(40), CTX, LIM, 1'b0, 32'h0, "R10 flushed below");
        // Push in the flush cycle is discarded.
        @(negedge clk);
        flush_i = 1'b1; push_i = 1'b1;
        push_gaddr_i = ga(42); push_ctx_i = CTX; push_lim_i = LIM; push_target_i = tg(42);
        @(negedge clk);
        flush_i = 1'b0; push_i = 1'b0;
        pop_chk(ga(42), CTX, LIM, 1'b0, 32'h0, "R10 push squashed");
        // Pop in the flush cycle gives no response.
        push(ga(43), CTX, LIM, tg(43));
        @(negedge clk);
        gaddr_we_i = 1'b1; gaddr_wdata_i = ga(43);
        @(negedge clk);
        gaddr_we_i = 1'b0; pop_i = 1'b1; flush_i = 1'b1; cur_ctx_i = CTX; cur_lim_i = LIM;
        @(negedge clk);
        pop_i = 1'b0; flush_i = 1'b0;
        check(pop_valid_o == 1'b0, "R10 pop squashed", 64'(pop_valid_o), 0);
    endtask

    task automatic t_swap;
        push(ga(50), CTX, LIM, tg(50));
        push(ga(51), CTX, LIM, tg(51));
        @(negedge clk);
        gaddr_we_i = 1'b1; gaddr_wdata_i = ga(51);
        @(negedge clk);
        gaddr_we_i = 1'b0; pop_i = 1'b1; cur_ctx_i = CTX; cur_lim_i = LIM;
        push_i = 1'b1; push_gaddr_i = ga(52); push_ctx_i = CTX; push_lim_i = LIM;
        push_target_i = tg(52);
        @(negedge clk);
        pop_i = 1'b0; push_i = 1'b0;
        check(pop_hit_o == 1'b1, "R11 old top hit", 64'(pop_hit_o), 1);
        check(pop_target_o == tg(51), "R11 old top target", 64'(pop_target_o), 64'(tg(51)));
        pop_chk(ga(52), CTX, LIM, 1'b1, tg(52), "R11 new top");
        pop_chk(ga(50), CTX, LIM, 1'b1, tg(50), "R11 below kept");
        pop_chk(ga(50), CTX, LIM, 1'b0, 32'h0, "R11 now empty");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_greg();
        t_basic_hit();
        t_field_miss();
        t_nesting();
        t_wrap();
        t_flush();
        t_swap();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule